// File: doc/BRIEF.md
# Masked priority interrupt encoder

This block gathers sixteen level-sensitive interrupt lines from local-bus devices and folds them into one request towards the processor. Each line is sampled into a source register on every clock, so a source bit follows its line. A 16-bit enable mask picks which sources may raise the request. The mask is reached through a small 16-bit register port with byte enables.

Software does not read the raw sources. A read at the vector offset returns a ready-made vector for the lowest-numbered source that is both active and enabled. The vector is the index plus one, shifted left by two, which gives a stride-four table offset. The value is zero when nothing is pending. Software services that source, the device drops its line, and the next read yields the next vector.

Top module: `masked_prio_irq`

## Requirements
- R1: Each source bit takes the level of its input line at every rising clock edge, so a line change shows in the source register one clock later and a dropped line clears its bit.
- R2: `cpu_irq_o` is registered and is high exactly when the source register ANDed with the enable mask is nonzero; it changes on the first rising edge after a line change or a mask write, and not before.
- R3: A read at byte offset 0 returns (n+1)<<2, where n is the lowest-numbered source that is both active and enabled; a lower index wins over any higher one.
- R4: A read at offset 0 returns 0 when no enabled source is active, including when active sources are all masked.
- R5: The enable mask sits at byte offset 2; a write there with both byte enables replaces all 16 bits and a read there returns the mask.
- R6: While `rst_ni` is low and after its release, the mask is 0x0010, the source register is 0 and `cpu_irq_o` is low.
- R7: In a mask write, `be_i[0]` enables bits 7:0 and `be_i[1]` enables bits 15:8; a disabled byte keeps its previous value.
- R8: A write at any offset other than 2 (odd addresses included) leaves the mask unchanged, and a read at any offset other than 0 or 2 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_lines_i | input | 16 | Level interrupt lines, bit n is source n |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset of the access |
| be_i | input | 2 | Byte enables for writes |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, combinational on the current state |
| cpu_irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
The source register, the mask and the request output all take their new values on the first rising edge after a line change or a mask write. Read data follows the stored state within the same cycle. The bench drives every input on a falling edge and checks results on the next falling edge. It issues reads combinationally half a cycle away from any rising edge. One directed check samples `cpu_irq_o` between the line change and the following edge, to confirm that the request has not yet moved.

// File: rtl/masked_irq_pkg.sv
package masked_irq_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_VEC  = 2'd1,
    SEL_MASK = 2'd2
  } reg_sel_e;

  localparam int unsigned VEC_SHIFT = 2;
endpackage

// File: rtl/irq_reg_decode.sv
module irq_reg_decode
  import masked_irq_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned VEC_OFFS  = 0,
  parameter int unsigned MASK_OFFS = 2
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  output reg_sel_e          sel_o
);
  always_comb begin
    sel_o = SEL_NONE;
    if (req_i) begin
      if (addr_i == ADDR_W'(VEC_OFFS))       sel_o = SEL_VEC;
      else if (addr_i == ADDR_W'(MASK_OFFS)) sel_o = SEL_MASK;
    end
  end
endmodule

// File: rtl/irq_src_latch.sv
module irq_src_latch #(
  parameter int unsigned N_SRC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] lines_i,
  output logic [N_SRC-1:0] src_q_o
);
  logic live_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q_o <= '0;
      live_q  <= 1'b0;
    end else begin
      src_q_o <= lines_i;
      live_q  <= 1'b1;
    end
  end

  // R1
  src_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (src_q_o == $past(lines_i)));
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
  parameter int unsigned           DATA_W   = 16,
  parameter logic [DATA_W-1:0]     MASK_RST = 16'h0010
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   mask_q_o,
  output logic [DATA_W-1:0]   mask_d_o
);
  localparam int unsigned NB = DATA_W / 8;

  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign mask_d_o[b*8 +: 8] = (wr_en_i && be_i[b]) ? wdata_i[b*8 +: 8]
                                                     : mask_q_o[b*8 +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q_o <= MASK_RST;
    else         mask_q_o <= mask_d_o;
  end

  // R8
  mask_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(mask_q_o));

  // R7
  byte_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !be_i[0]) |=> (mask_q_o[7:0] == $past(mask_q_o[7:0])));
endmodule

// File: rtl/irq_prio_vec.sv
module irq_prio_vec
  import masked_irq_pkg::*;
#(
  parameter int unsigned N_SRC  = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic [N_SRC-1:0]  pend_i,
  output logic [DATA_W-1:0] vec_o,
  output logic              any_o
);
  localparam int unsigned IDX_W = $clog2(N_SRC);

  logic [IDX_W-1:0] idx;
  logic [IDX_W:0]   num;

  always_comb begin
    idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (pend_i[i]) idx = IDX_W'(i);
    end
  end

  assign any_o = |pend_i;
  assign num   = {1'b0, idx} + 1'b1;
  assign vec_o = any_o ? (DATA_W'(num) << VEC_SHIFT) : '0;

  int unsigned chk_idx;
  always_comb begin
    chk_idx = (32'(vec_o) >> VEC_SHIFT) - 1;
    // R4
    if (pend_i == '0) begin
      vec_zero_chk: assert (vec_o == '0);
    end
    // R3
    if (pend_i != '0) begin
      vec_lowest_chk: assert (vec_o[1:0] == 2'b00 && chk_idx < N_SRC &&
                              pend_i[chk_idx[IDX_W-1:0]] &&
                              ((pend_i & ((N_SRC'(1) << chk_idx[IDX_W-1:0]) - 1'b1)) == '0));
    end
  end
endmodule

// File: rtl/masked_prio_irq.sv
module masked_prio_irq
  import masked_irq_pkg::*;
#(
  parameter int unsigned       N_SRC     = 16,
  parameter int unsigned       DATA_W    = 16,
  parameter int unsigned       ADDR_W    = 4,
  parameter int unsigned       VEC_OFFS  = 0,
  parameter int unsigned       MASK_OFFS = 2,
  parameter logic [DATA_W-1:0] MASK_RST  = 16'h0010
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_SRC-1:0]    irq_lines_i,
  input  logic                req_i,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [DATA_W/8-1:0] be_i,
  input  logic [DATA_W-1:0]   wdata_i,
  output logic [DATA_W-1:0]   rdata_o,
  output logic                cpu_irq_o
);
  reg_sel_e          sel;
  logic              mask_wr;
  logic [DATA_W-1:0] mask_q, mask_d, vec;
  logic [N_SRC-1:0]  src_q, pend;
  logic              any_pend;

  irq_reg_decode #(
    .ADDR_W(ADDR_W), .VEC_OFFS(VEC_OFFS), .MASK_OFFS(MASK_OFFS)
  ) u_dec (
    .req_i(req_i), .addr_i(addr_i), .sel_o(sel)
  );

  assign mask_wr = we_i && (sel == SEL_MASK);

  irq_mask_reg #(.DATA_W(DATA_W), .MASK_RST(MASK_RST)) u_mask (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(mask_wr), .be_i(be_i),
    .wdata_i(wdata_i), .mask_q_o(mask_q), .mask_d_o(mask_d)
  );

  irq_src_latch #(.N_SRC(N_SRC)) u_src (
    .clk_i(clk_i), .rst_ni(rst_ni), .lines_i(irq_lines_i), .src_q_o(src_q)
  );

  assign pend = src_q & mask_q[N_SRC-1:0];

  irq_prio_vec #(.N_SRC(N_SRC), .DATA_W(DATA_W)) u_prio (
    .pend_i(pend), .vec_o(vec), .any_o(any_pend)
  );

  // request computed from next-state values so it lands with src/mask
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cpu_irq_o <= 1'b0;
    else         cpu_irq_o <= |(irq_lines_i & mask_d[N_SRC-1:0]);
  end

  always_comb begin
    unique case (sel)
      SEL_VEC:  rdata_o = vec;
      SEL_MASK: rdata_o = mask_q;
      default:  rdata_o = '0;
    endcase
  end

  // R2
  irq_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_irq_o == any_pend);

  // R8
  other_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && addr_i != ADDR_W'(VEC_OFFS) && addr_i != ADDR_W'(MASK_OFFS)) |-> (rdata_o == '0));
endmodule

// File: tb/sim_masked_prio_irq.sv
`timescale 1ns/1ps
module sim_masked_prio_irq;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] lines = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  be = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        irq;

  int checks = 0, errors = 0;
  logic [15:0] m_mask, m_lines;
  logic        done = 1'b0;

  always #2.5 clk = ~clk;

  masked_prio_irq u0 (
    .clk_i(clk), .rst_ni(rst_ni), .irq_lines_i(lines), .req_i(req), .we_i(we),
    .addr_i(addr), .be_i(be), .wdata_i(wdata), .rdata_o(rdata), .cpu_irq_o(irq)
  );

  function automatic logic [15:0] exp_vec(logic [15:0] l, logic [15:0] m);
    logic [15:0] v = '0;
    for (int i = 15; i >= 0; i--) if (l[i] && m[i]) v = 16'((i + 1) << 2);
    return v;
  endfunction

  task automatic chk(string req_tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic rd(logic [3:0] a, output logic [15:0] d);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    req = 1'b0;
  endtask

  task automatic wr(logic [3:0] a, logic [1:0] b, logic [15:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; be = b; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; be = '0;
  endtask

  task automatic set_lines(logic [15:0] v);
    @(negedge clk);
    lines = v; m_lines = v;
    @(negedge clk);
  endtask

  task automatic check_all(string tag);
    logic [15:0] d;
    chk({tag, " R2 irq"}, {15'd0, irq}, {15'd0, |(m_lines & m_mask)});
    rd(4'd0, d);
    chk({tag, " R3 vec"}, d, exp_vec(m_lines, m_mask));
    rd(4'd2, d);
    chk({tag, " R5 mask"}, d, m_mask);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual hung expected done");
    finish_run();
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'h5eed1234));
    // R6: reset holds even with all lines high
    lines = 16'hffff;
    repeat (3) @(negedge clk);
    chk("R6 irq in reset", {15'd0, irq}, 16'd0);
    rd(4'd0, d); chk("R6 vec in reset", d, 16'd0);
    rd(4'd2, d); chk("R6 mask in reset", d, 16'h0010);
    lines = '0; m_lines = '0; m_mask = 16'h0010;
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk);
    check_all("R6 after reset");

    // R1/R2: line 4 enabled by reset mask; irq must not move before edge
    @(negedge clk);
    lines = 16'h0010; m_lines = 16'h0010;
    #1 chk("R2 irq before edge", {15'd0, irq}, 16'd0);
    @(negedge clk);
    chk("R1 R2 irq after edge", {15'd0, irq}, 16'd1);
    rd(4'd0, d); chk("R1 vec line4", d, 16'd20);
    set_lines(16'h0008);
    check_all("R4 masked only");
    rd(4'd0, d); chk("R4 vec zero", d, 16'd0);

    // R5 full write, R3 priority
    wr(4'd2, 2'b11, 16'hffff); m_mask = 16'hffff;
    check_all("R5 full");
    set_lines(16'h8001); rd(4'd0, d); chk("R3 lowest wins", d, 16'd4);
    set_lines(16'h8000); rd(4'd0, d); chk("R3 top source", d, 16'd64);
    set_lines(16'h0000); check_all("R1 line dropped");

    // R7 byte merge
    wr(4'd2, 2'b01, 16'hab12); m_mask = 16'hff12;
    rd(4'd2, d); chk("R7 low byte", d, 16'hff12);
    wr(4'd2, 2'b10, 16'h34cd); m_mask = 16'h3412;
    rd(4'd2, d); chk("R7 high byte", d, 16'h3412);
    wr(4'd2, 2'b00, 16'h0000);
    rd(4'd2, d); chk("R7 no enables", d, 16'h3412);

    // R8 other offsets
    wr(4'd4, 2'b11, 16'h0000); rd(4'd2, d); chk("R8 write off4", d, 16'h3412);
    wr(4'd3, 2'b11, 16'h0000); rd(4'd2, d); chk("R8 write odd", d, 16'h3412);
    wr(4'd0, 2'b11, 16'h0000); rd(4'd2, d); chk("R8 write vec", d, 16'h3412);
    set_lines(16'h0002);
    rd(4'd4, d); chk("R8 read off4", d, 16'd0);
    rd(4'd1, d); chk("R8 read odd", d, 16'd0);
    rd(4'd14, d); chk("R8 read offE", d, 16'd0);
    check_all("R2 mask write effect");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op = $urandom_range(0, 7);
      if (op < 5) begin
        set_lines(16'($urandom & $urandom));
      end else if (op == 5) begin
        logic [1:0]  b = 2'($urandom);
        logic [15:0] v = 16'($urandom);
        wr(4'd2, b, v);
        if (b[0]) m_mask[7:0]  = v[7:0];
        if (b[1]) m_mask[15:8] = v[15:8];
      end else begin
        logic [3:0] a = 4'($urandom);
        if (a == 4'd2) a = 4'd6;
        wr(a, 2'b11, 16'($urandom));
      end
      check_all("random");
    end
    finish_run();
  end
endmodule